// File: doc/BRIEF.md
# Atomic Reservation Memory Unit

This block fronts a small single-ported data memory shared by several requesters and gives them the primitives that lock and counter code is built from. Each requester can issue a plain load or store, a linked load, a conditional store, an atomic swap, a test-and-set and a fetch-and-increment. A round-robin arbiter admits one request at a time. Each admitted request then runs to completion before the next grant, so every read-modify-write is indivisible.

The unit holds one reservation per requester, made of a valid bit and a word address. A linked load sets the reservation. Any write to memory clears every reservation on the written word. A conditional store commits only while its own port still holds a matching reservation.

The controller is a four-state machine. ST_IDLE grants the chosen requester and latches its request (transition T_GRANT to ST_READ). ST_READ reads the addressed word into a register (T_FETCH to ST_WRITE). ST_WRITE computes the result, writes memory if the operation calls for it and updates the reservations (T_COMMIT to ST_RESP). ST_RESP presents the response to the granted port (T_REPLY back to ST_IDLE).

Top module: `atomic_resv_unit`

## Requirements
- R1: After reset there is no grant and no response. All words of memory read 0 and every reservation is invalid, so a conditional store issued first fails.
- R2: A grant is one-hot and goes only to a port with `req_valid` high, in a cycle when the unit is idle. The granted port sees `rsp_valid` for exactly one cycle, three cycles after its grant, with `rsp_data` valid in that cycle. The next grant can come no earlier than the cycle after that response.
- R3: The arbiter searches round-robin, starting from the port after the last one granted. After reset, port 0 has the highest priority.
- R4: Opcode 0 (load) returns the addressed word. Opcode 1 (store) writes `wdata` and returns 0.
- R5: Opcode 2 (linked load) returns the word and records a reservation for the port on that address. A later linked load from the same port replaces the earlier reservation.
- R6: Opcode 3 (conditional store) writes `wdata` and returns 1 only when its port holds a valid reservation on the same address.
- R7: A conditional store without a matching reservation writes nothing, returns 0 and leaves all reservations unchanged.
- R8: Every memory write clears all reservations on the written address, including the writer's own. The writes are a store, a successful conditional store, a swap, a test-and-set that sets, and a fetch-and-increment. Reservations on other addresses survive.
- R9: Opcode 4 (swap) writes `wdata` and returns the previous word.
- R10: Opcode 5 (test-and-set) returns the previous word and writes 1 only if that word was 0. When the word is nonzero, memory and reservations are left untouched.
- R11: Opcode 6 (fetch-and-increment) returns the previous word and stores it plus one, modulo 2^DW.
- R12: Concurrent read-modify-writes from different ports to one word never interleave, so N increments raise the word by exactly N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Per-port request, held until granted |
| req_op | input | NPORT*3 | Per-port opcode, port p at bits [3p+2:3p] |
| req_addr | input | NPORT*AW | Per-port word address |
| req_wdata | input | NPORT*DW | Per-port write data |
| req_gnt | output | NPORT | One-hot grant, request latched in that cycle |
| rsp_valid | output | NPORT | One-cycle response strobe for the granted port |
| rsp_data | output | DW | Response value, valid while any rsp_valid is high |

## Verification
The bench checks that a conditional store fails in three cases:
- after another port stores to the reserved word;
- after the port's own successful conditional store consumed its reservation;
- after a second linked load moved the reservation elsewhere.

A design that compared only addresses, or that forgot to clear the writer's own entry, would return 1 in one of these cases.

The bench also checks that a test-and-set finding a nonzero word does not break a pending reservation. It checks that fetch-and-increment wraps from all ones to zero. Finally, three ports hammer one counter with increments; a unit that let a grant slip in between the read and the write would lose counts and miss the final total.

// File: rtl/atom_pkg.sv
package atom_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_SWAP  = 3'd4,
        OP_TAS   = 3'd5,
        OP_FINC  = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } fsm_e;
endpackage

// File: rtl/atom_rr_arbiter.sv
module atom_rr_arbiter #(
    parameter int NPORT = 3,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic             enable,
    output logic [NPORT-1:0] gnt,
    output logic [IW-1:0]    gnt_idx
);
    logic [IW-1:0] last_q;

    // Walk from farthest to nearest so the port just after last_q wins.
    always_comb begin
        int cand;
        gnt     = '0;
        gnt_idx = '0;
        for (int off = NPORT; off >= 1; off--) begin
            cand = (int'(last_q) + off) % NPORT;
            if (enable && req[cand]) begin
                gnt       = '0;
                gnt[cand] = 1'b1;
                gnt_idx   = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(NPORT - 1);
        end else if (|gnt) begin
            last_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/atom_op_exec.sv
module atom_op_exec
    import atom_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] new_word,
    input  logic          resv_ok,
    output logic          we,
    output logic [DW-1:0] wr_word,
    output logic [DW-1:0] result,
    output logic          link
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_comb begin
        we      = 1'b0;
        wr_word = new_word;
        result  = old_word;
        link    = 1'b0;
        unique case (op)
            OP_LOAD: ;
            OP_STORE: begin
                we     = 1'b1;
                result = '0;
            end
            OP_LL: link = 1'b1;
            OP_SC: begin
                we     = resv_ok;
                result = resv_ok ? ONE : '0;
            end
            OP_SWAP: we = 1'b1;
            OP_TAS: begin
                we      = (old_word == '0);
                wr_word = ONE;
            end
            OP_FINC: begin
                we      = 1'b1;
                wr_word = old_word + ONE;
            end
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/atom_resv_table.sv
module atom_resv_table #(
    parameter int NPORT = 3,
    parameter int AW    = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_port,
    input  logic [AW-1:0] set_addr,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic [IW-1:0] chk_port,
    input  logic [AW-1:0] chk_addr,
    output logic          chk_hit
);
    logic [NPORT-1:0] vld_q;
    logic [AW-1:0]    adr_q [NPORT];

    for (genvar g = 0; g < NPORT; g++) begin : g_entry
        logic          vld_r;
        logic [AW-1:0] adr_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
                adr_r <= '0;
            end else if (set_en && set_port == IW'(g)) begin
                vld_r <= 1'b1;
                adr_r <= set_addr;
            end else if (clr_en && adr_r == clr_addr) begin
                vld_r <= 1'b0;
            end
        end

        assign vld_q[g] = vld_r;
        assign adr_q[g] = adr_r;

        AST_RESV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && vld_r && adr_r == clr_addr) |=> !vld_r); // R8
    end

    assign chk_hit = vld_q[chk_port] && (adr_q[chk_port] == chk_addr);
endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit
    import atom_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      req_valid,
    input  logic [NPORT*OP_W-1:0] req_op,
    input  logic [NPORT*AW-1:0]   req_addr,
    input  logic [NPORT*DW-1:0]   req_wdata,
    output logic [NPORT-1:0]      req_gnt,
    output logic [NPORT-1:0]      rsp_valid,
    output logic [DW-1:0]         rsp_data
);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1;

    fsm_e          state_q, state_d;
    logic [NPORT-1:0] pick_oh;
    logic [IW-1:0] pick_idx, port_q;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rd_q, rsp_q;
    logic [DW-1:0] mem_q [DEPTH];

    logic          arb_en, resv_hit, commit;
    logic          ex_we, ex_link;
    logic [DW-1:0] ex_word, ex_result;

    atom_rr_arbiter #(.NPORT(NPORT), .IW(IW)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .enable  (arb_en),
        .gnt     (pick_oh),
        .gnt_idx (pick_idx)
    );

    atom_op_exec #(.DW(DW)) i_exec (
        .op       (op_q),
        .old_word (rd_q),
        .new_word (wdata_q),
        .resv_ok  (resv_hit),
        .we       (ex_we),
        .wr_word  (ex_word),
        .result   (ex_result),
        .link     (ex_link)
    );

    atom_resv_table #(.NPORT(NPORT), .AW(AW), .IW(IW)) i_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (state_q == ST_WRITE && ex_link),
        .set_port (port_q),
        .set_addr (addr_q),
        .clr_en   (commit),
        .clr_addr (addr_q),
        .chk_port (port_q),
        .chk_addr (addr_q),
        .chk_hit  (resv_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_GRANT, T_FETCH, T_COMMIT, T_REPLY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (|pick_oh) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        arb_en    = (state_q == ST_IDLE);
        req_gnt   = pick_oh;
        commit    = (state_q == ST_WRITE) && ex_we;
        rsp_valid = '0;
        if (state_q == ST_RESP) rsp_valid[port_q] = 1'b1;
        rsp_data  = rsp_q;
    end

    // Request capture, read and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q  <= '0;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            rsp_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && |pick_oh) begin
                port_q  <= pick_idx;
                op_q    <= op_e'(req_op[pick_idx*OP_W +: OP_W]);
                addr_q  <= req_addr[pick_idx*AW +: AW];
                wdata_q <= req_wdata[pick_idx*DW +: DW];
            end
            if (state_q == ST_READ)  rd_q  <= mem_q[addr_q];
            if (state_q == ST_WRITE) rsp_q <= ex_result;
        end
    end

    // Data memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit) begin
            mem_q[addr_q] <= ex_word;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_gnt) && ((req_gnt & ~req_valid) == '0)); // R2
    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R2
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_gnt) |-> ##3 (|rsp_valid)); // R2
    AST_TAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && op_q == OP_TAS && rd_q != '0)
        |=> mem_q[addr_q] == $past(rd_q)); // R10
    AST_FINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && op_q == OP_FINC)
        |=> mem_q[addr_q] == $past(rd_q + {{(DW-1){1'b0}}, 1'b1})); // R11
endmodule

// File: tb/test_atomic_resv_unit.sv
`timescale 1ns/1ps
module test_atomic_resv_unit;
    localparam int NP = 3;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int OW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_valid = '0;
    logic [NP*OW-1:0] req_op    = '0;
    logic [NP*AW-1:0] req_addr  = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]    req_gnt, rsp_valid;
    logic [DW-1:0]    rsp_data;

    always #4 clk = ~clk;

    atomic_resv_unit #(.NPORT(NP), .AW(AW), .DW(DW)) i_atomic_resv_unit (
        .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata,
        .req_gnt, .rsp_valid, .rsp_data
    );

    typedef struct {
        int    op;
        int    addr;
        int    wd;
        string tag;
    } item_t;

    item_t q0[$], q1[$], q2[$];
    item_t cur [NP];
    bit    busy [NP];

    int checks = 0, fails = 0;
    int mm [16];
    bit rv [NP];
    int ra [NP];
    int m_phase = 0, m_port = 0, m_last = NP - 1, m_rsp = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int qsize(int p);
        if (p == 0) return q0.size();
        if (p == 1) return q1.size();
        return q2.size();
    endfunction

    function automatic item_t qhead(int p);
        if (p == 0) return q0[0];
        if (p == 1) return q1[0];
        return q2[0];
    endfunction

    task automatic qpop(int p);
        if (p == 0) void'(q0.pop_front());
        else if (p == 1) void'(q1.pop_front());
        else void'(q2.pop_front());
    endtask

    task automatic push(int p, int op, int addr, int wd, string tag);
        item_t it;
        it.op = op; it.addr = addr; it.wd = wd; it.tag = tag;
        if (p == 0) q0.push_back(it);
        else if (p == 1) q1.push_back(it);
        else q2.push_back(it);
    endtask

    function automatic void clr_resv(int a);
        for (int i = 0; i < NP; i++) if (ra[i] == a) rv[i] = 1'b0;
    endfunction

    // Reference behaviour of one admitted request
    function automatic int execute(int p, item_t it);
        int old;
        int r;
        old = mm[it.addr];
        r = old;
        case (it.op)
            1: begin mm[it.addr] = it.wd & 255; clr_resv(it.addr); r = 0; end
            2: begin rv[p] = 1'b1; ra[p] = it.addr; end
            3: begin
                if (rv[p] && ra[p] == it.addr) begin
                    mm[it.addr] = it.wd & 255; clr_resv(it.addr); r = 1;
                end else r = 0;
            end
            4: begin mm[it.addr] = it.wd & 255; clr_resv(it.addr); end
            5: if (old == 0) begin mm[it.addr] = 1; clr_resv(it.addr); end
            6: begin mm[it.addr] = (old + 1) & 255; clr_resv(it.addr); end
            default: ;
        endcase
        return r;
    endfunction

    // One clock of stimulus, comparison and model advance
    task automatic step();
        int pick;
        int exp_gnt;
        item_t it;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            if (qsize(p) > 0 && !busy[p]) begin
                it = qhead(p);
                req_valid[p] = 1'b1;
                req_op[p*OW +: OW]    = OW'(it.op);
                req_addr[p*AW +: AW]  = AW'(it.addr);
                req_wdata[p*DW +: DW] = DW'(it.wd);
            end else begin
                req_valid[p] = 1'b0;
            end
        end
        #1;
        pick = -1;
        if (m_phase == 0) begin
            for (int off = 1; off <= NP; off++) begin
                int c;
                c = (m_last + off) % NP;
                if (pick < 0 && req_valid[c]) pick = c;
            end
        end
        exp_gnt = (pick >= 0) ? (1 << pick) : 0;
        chk("R3 grant", int'(req_gnt), exp_gnt);
        if (m_phase == 3) begin
            chk("R2 response strobe", int'(rsp_valid), 1 << m_port);
            chk(cur[m_port].tag, int'(rsp_data), m_rsp);
        end else begin
            chk("R2 no response", int'(rsp_valid), 0);
        end
        case (m_phase)
            0: if (pick >= 0) begin
                cur[pick] = qhead(pick);
                qpop(pick);
                busy[pick] = 1'b1;
                m_port = pick;
                m_last = pick;
                m_rsp = execute(pick, cur[pick]);
                m_phase = 1;
            end
            1, 2: m_phase++;
            default: begin
                busy[m_port] = 1'b0;
                m_phase = 0;
            end
        endcase
    endtask

    task automatic run_batch();
        int guard;
        guard = 0;
        do begin
            step();
            guard++;
        end while ((q0.size() + q1.size() + q2.size() > 0 || m_phase != 0) && guard < 5000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mm[i] = 0;
        for (int i = 0; i < NP; i++) begin rv[i] = 0; ra[i] = 0; busy[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset grant", int'(req_gnt), 0);
        chk("R1 reset response", int'(rsp_valid), 0);

        // R1 / R7: reservation table empty after reset; memory reads zero
        push(0, 3, 3, 8'h5A, "R1 sc after reset fails");
        run_batch();
        push(1, 0, 3, 0, "R7 failed sc left word");
        push(2, 0, 0, 0, "R1 memory zero");
        run_batch();

        // R4: store then load
        push(0, 1, 1, 8'h11, "R4 store returns zero");
        push(0, 0, 1, 0, "R4 load");
        run_batch();

        // R6 / R8: own successful sc consumes the reservation
        push(0, 2, 2, 0, "R5 ll value");
        push(0, 3, 2, 8'h22, "R6 sc success");
        push(0, 3, 2, 8'h23, "R8 own reservation cleared");
        push(0, 0, 2, 0, "R6 sc wrote");
        run_batch();

        // R8: foreign store breaks the link
        push(1, 2, 4, 0, "R5 ll value");
        run_batch();
        push(2, 1, 4, 5, "R4 store");
        run_batch();
        push(1, 3, 4, 8'h77, "R8 foreign store clears");
        run_batch();
        push(1, 0, 4, 0, "R7 no write on fail");
        run_batch();

        // R8: store to a different word leaves the link alone
        push(1, 2, 5, 0, "R5 ll value");
        run_batch();
        push(2, 1, 6, 9, "R4 store");
        run_batch();
        push(1, 3, 5, 8'h44, "R8 other address survives");
        run_batch();

        // R5: second ll replaces the first
        push(0, 2, 7, 0, "R5 ll first");
        push(0, 2, 8, 0, "R5 ll second");
        push(0, 3, 7, 8'h31, "R5 replaced reservation");
        push(0, 3, 8, 8'h32, "R7 failed sc kept reservation");
        run_batch();

        // R9: swap
        push(2, 4, 1, 8'h99, "R9 swap old");
        push(2, 0, 1, 0, "R9 swap wrote");
        run_batch();

        // R10: test-and-set
        push(1, 5, 9, 0, "R10 tas free");
        run_batch();
        push(2, 5, 9, 0, "R10 tas locked");
        run_batch();
        push(0, 1, 10, 3, "R4 store");
        run_batch();
        push(1, 2, 10, 0, "R5 ll value");
        run_batch();
        push(2, 5, 10, 0, "R10 tas nonzero");
        run_batch();
        push(1, 3, 10, 8'h55, "R10 tas kept reservation");
        run_batch();

        // R11: increment wraps
        push(0, 1, 11, 8'hFF, "R4 store");
        push(0, 6, 11, 0, "R11 finc old");
        push(0, 0, 11, 0, "R11 finc wrap");
        run_batch();

        // R12 / R3: contended increments, all ports at once
        for (int k = 0; k < 6; k++) begin
            push(0, 6, 12, 0, "R12 finc");
            push(1, 6, 12, 0, "R12 finc");
            push(2, 6, 12, 0, "R12 finc");
        end
        run_batch();
        push(1, 0, 12, 0, "R12 counter total");
        run_batch();
        chk("R12 model total", mm[12], 18);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule